// File: doc/BRIEF.md
# Two-Lane I2S Bus Master

This block is the clock-owning end of an I2S link that carries two stereo streams in each direction. It divides the system clock down to one bit clock and one word-select clock. Both serial output lanes and both serial input lanes share that single pair of clocks, so all four transmit channels and all four receive channels always run at one common sample rate.

On the parallel side, one 64-bit group holds the four 16-bit signed samples of a frame. Slot 0 is lane 0 left, slot 1 is lane 1 left, slot 2 is lane 0 right and slot 3 is lane 1 right. Slot s occupies bits [16*s+15:16*s].

The transmit group is accepted at each frame boundary through a one-cycle ready strobe. If the upstream has nothing valid at that moment, a silent frame goes out and an underrun flag is raised. The receive group is delivered once per frame, with a single-cycle valid strobe, after the last right-channel bit has been captured.

Top module: `i2s_quad_master`

## Requirements
- R1: The bit clock toggles every DIV system cycles, giving a period of 2*DIV cycles with equal high and low phases. One frame spans 32 bit-clock periods.
- R2: Word-select is low for left words and high for right words. It changes only with a falling bit-clock edge, exactly one bit period before the MSB of the next word.
- R3: Each output lane changes only with a falling bit-clock edge. It sends each 16-bit word MSB first, starting one bit period after the word-select transition.
- R4: tx_ready is high for one system cycle, in the cycle whose clock edge starts a frame. A group presented with tx_valid in that cycle is sent in that frame: lane 0 carries slot 0 then slot 2, and lane 1 carries slot 1 then slot 3.
- R5: If tx_valid is low while tx_ready is high, both lanes send all zeros for that frame, and tx_underrun is high for exactly the following cycle.
- R6: Input lanes are captured on rising bit-clock edges. After the last right-channel bit of a frame is captured, rx_samples is updated in the slot order of R4, and rx_valid pulses for one cycle.
- R7: An input lane held high yields samples of 16'hFFFF (-1). An input lane held low yields samples of 0.
- R8: While rst is high, the bit clock, word-select and both output lanes are low, and rx_valid, tx_ready and tx_underrun are low.
- R9: Lane 1 follows exactly the same bit timing as lane 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit group available |
| tx_ready | output | 1 | Frame boundary, transmit group taken this cycle |
| tx_samples | input | 64 | Transmit group, four 16-bit slots |
| tx_underrun | output | 1 | One-cycle flag: silent frame loaded |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word-select, low = left |
| sd_out | output | 2 | Serial output lanes 1..0 |
| sd_in | input | 2 | Serial input lanes 1..0 |
| rx_valid | output | 1 | One-cycle strobe: new receive group |
| rx_samples | output | 64 | Receive group, four 16-bit slots |

## Verification
A wrong divider count or bit position shows at bclk or ws within one bit period, and on every following frame. A wrong slot mapping or shift direction corrupts sd_out in the first word sent after the fault. On the receive side, the same kind of fault corrupts rx_samples at the very next rx_valid, no later than one frame after the fault. A reference model that tracks every system cycle compares each of these outputs on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/i2s_quad_master.sv
module i2s_quad_master #(
  parameter int SW  = 16,
  parameter int DIV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [4*SW-1:0] tx_samples,
  output logic            tx_underrun,
  output logic            bclk,
  output logic            ws,
  output logic [1:0]      sd_out,
  input  logic [1:0]      sd_in,
  output logic            rx_valid,
  output logic [4*SW-1:0] rx_samples
);
  localparam int FW = 2 * SW;
  localparam int PW = $clog2(FW);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [PW-1:0] pos;
  logic          primed;
  logic [FW-1:0] tsr0, tsr1, rsr0, rsr1;

  wire tick = (cnt == CW'(DIV - 1));
  wire fall = tick & bclk;
  wire rise = tick & ~bclk;
  wire [PW-1:0] pos_nx = (pos == PW'(FW - 1)) ? '0 : pos + PW'(1);
  wire frame_start = fall && (pos == PW'(FW - 1));
  wire [4*SW-1:0] grp = tx_valid ? tx_samples : '0;
  wire [FW-1:0] rn0 = {rsr0[FW-2:0], sd_in[0]};
  wire [FW-1:0] rn1 = {rsr1[FW-2:0], sd_in[1]};

  assign tx_ready = frame_start;
  assign sd_out   = {tsr1[FW-1], tsr0[FW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      bclk        <= 1'b0;
      ws          <= 1'b0;
      pos         <= PW'(FW - 1);
      primed      <= 1'b0;
      tsr0        <= '0;
      tsr1        <= '0;
      rsr0        <= '0;
      rsr1        <= '0;
      tx_underrun <= 1'b0;
      rx_valid    <= 1'b0;
      rx_samples  <= '0;
    end else begin
      cnt         <= tick ? '0 : cnt + CW'(1);
      tx_underrun <= frame_start & ~tx_valid;
      rx_valid    <= 1'b0;
      if (tick) bclk <= ~bclk;
      if (fall) begin
        pos <= pos_nx;
        ws  <= (pos_nx >= PW'(SW - 1)) && (pos_nx <= PW'(FW - 2));
        if (frame_start) begin
          tsr0   <= {grp[0*SW +: SW], grp[2*SW +: SW]};
          tsr1   <= {grp[1*SW +: SW], grp[3*SW +: SW]};
          primed <= 1'b1;
        end else begin
          tsr0 <= tsr0 << 1;
          tsr1 <= tsr1 << 1;
        end
      end
      if (rise) begin
        rsr0 <= rn0;
        rsr1 <= rn1;
        if (primed && pos == PW'(FW - 1)) begin
          rx_valid   <= 1'b1;
          rx_samples <= {rn1[SW-1:0], rn0[SW-1:0], rn1[FW-1:SW], rn0[FW-1:SW]};
        end
      end
    end
  end

  assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (ws != $past(ws)) |-> $fell(bclk));
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (sd_out != $past(sd_out)) |-> $fell(bclk));
  assert_ready_at_boundary_R4: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> ($fell(bclk) && !ws));
  assert_silent_underrun_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !tx_valid) |=> (tx_underrun && sd_out == 2'b00));
  assert_rx_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(bclk));
  assert_rx_single_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!bclk && !ws && sd_out == 2'b00 && !rx_valid && !tx_underrun));
endmodule

// File: tb/test_i2s_quad_master.sv
module test_i2s_quad_master;
  localparam int D = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic tx_valid = 1'b0, tx_ready, tx_underrun, bclk, ws, rx_valid;
  logic [63:0] tx_samples = '0, rx_samples;
  logic [1:0] sd_out, sd_in = 2'b00;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  i2s_quad_master #(.SW(16), .DIV(D)) i_i2s_quad_master (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_samples(tx_samples), .tx_underrun(tx_underrun), .bclk(bclk), .ws(ws),
    .sd_out(sd_out), .sd_in(sd_in), .rx_valid(rx_valid), .rx_samples(rx_samples));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pick_tx(int f);
    return {16'(f * 3 + 16'h8001), 16'(16'h7FFF - f), 16'(f * 16'h1111), $urandom()} & 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (2000 * 12) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int k, falls, q, n_new, m, fr, loads;
    logic [63:0] cur_grp, nx_rxd;
    logic [31:0] rb0, rb1;
    logic nx_und, nx_rxv, ld_next, just_loaded, want_r7hi, want_r7lo;
    k = 0; loads = 0; cur_grp = '0; nx_rxd = '0; rb0 = '0; rb1 = '0;
    nx_und = 0; nx_rxv = 0; just_loaded = 0; want_r7hi = 0; want_r7lo = 0;
    repeat (3) @(negedge clk);
    chk("R8 bclk", 64'(bclk), 0);
    chk("R8 ws", 64'(ws), 0);
    chk("R8 sd_out", 64'(sd_out), 0);
    chk("R8 flags", {61'd0, rx_valid, tx_ready, tx_underrun}, 0);
    tx_valid = 1'b1;
    tx_samples = pick_tx(0);
    rst = 1'b0;
    forever begin
      @(negedge clk);
      k++;
      falls = (k / D) / 2;
      q = (falls - 1) % 32;
      chk("R1 bclk", 64'(bclk), 64'((k / D) % 2));
      chk("R2 ws", 64'(ws), 64'(falls >= 1 && q >= 15 && q <= 30));
      if (falls >= 1) begin
        chk("R3 lane0", 64'(sd_out[0]), 64'(cur_grp[(q < 16 ? 0 : 32) + 15 - q % 16]));
        chk("R9 lane1", 64'(sd_out[1]), 64'(cur_grp[(q < 16 ? 16 : 48) + 15 - q % 16]));
      end else chk("R3 idle", 64'(sd_out), 0);
      chk("R5 underrun", 64'(tx_underrun), 64'(nx_und));
      chk("R6 rx_valid", 64'(rx_valid), 64'(nx_rxv));
      if (nx_rxv) begin
        chk("R6 R9 rx_samples", rx_samples, nx_rxd);
        if (want_r7hi) chk("R7 high lane", rx_samples, 64'hFFFF_FFFF_FFFF_FFFF);
        if (want_r7lo) chk("R7 low lane", rx_samples, 64'h0);
      end
      nx_und = 0; nx_rxv = 0; want_r7hi = 0; want_r7lo = 0;
      if (just_loaded) begin
        tx_valid = !(loads == 4 || loads == 8);
        tx_samples = pick_tx(loads);
        just_loaded = 0;
      end
      fr = (falls == 0) ? 0 : (falls - 1) / 32;
      if (fr >= 12) break;
      if (fr == 5 || fr == 6) sd_in = 2'b11;
      else if (fr == 7 || fr == 8) sd_in = 2'b00;
      else sd_in = 2'($urandom());
      n_new = (k + 1) / D;
      ld_next = ((k + 1) % D == 0) && (n_new % 2 == 0) && ((n_new / 2 - 1) % 32 == 0);
      chk("R4 tx_ready", 64'(tx_ready), 64'(ld_next));
      if (ld_next) begin
        cur_grp = tx_valid ? tx_samples : 64'h0;
        nx_und = !tx_valid;
        loads++;
        just_loaded = 1;
      end
      if (((k + 1) % D == 0) && (n_new % 2 == 1)) begin
        m = n_new / 2;
        rb0 = {rb0[30:0], sd_in[0]};
        rb1 = {rb1[30:0], sd_in[1]};
        if (m >= 1 && (m - 1) % 32 == 31) begin
          nx_rxv = 1;
          nx_rxd = {rb1[15:0], rb0[15:0], rb1[31:16], rb0[31:16]};
          want_r7hi = ((m - 1) / 32 == 5);
          want_r7lo = ((m - 1) / 32 == 7);
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule